// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block is the address front end of a pipelined synchronous burst memory. On a rising clock edge it captures an external word address when one of two active-low address strobes is asserted and the chip-select inputs select the device. One strobe comes from the processor and is honoured only while chip enable is active. The other comes from the cache controller and is not gated. A strobe that arrives while the device is not selected starts a deselect cycle instead of a load.

After a load, the two low address bits are stepped through a four-beat burst. Each clock with the advance input low and no strobe moves the burst one beat. With advance held high the burst is suspended and the current address is reused. The beat order is either linear (modulo-4 increment) or interleaved (start XOR beat count). A static order pin picks the order, and it is sampled once as the block leaves reset. The upper address bits stay at the loaded value for the whole burst. The block outputs the internal word address, a selected flag, and a flag that shows whether the processor strobe started the current access.

Top module: `burst_addr_seq`

## Requirements
- R1: On a clock edge where the device is selected (chip enable low, high-true select high, low-true select low) and either the controller strobe is low or the processor strobe is low, `word_addr` equals the sampled `addr_in` after that edge and `selected` is 1.
- R2: While chip enable is high, a low processor strobe is ignored. With the controller strobe high, the edge acts as a plain advance or hold cycle, and the address and flags are unaffected by the processor strobe.
- R3: An accepted strobe (controller strobe low, or processor strobe low with chip enable low) while the device is not selected clears `selected` and `cpu_started` and leaves `word_addr` unchanged.
- R4: With no accepted strobe and `advance_n` high, `word_addr` and `selected` hold their values.
- R5: During a burst, the bits of `word_addr` above bit 1 keep the loaded value and ignore `addr_in`.
- R6: With the captured order mode 0 (linear), each advance adds 1 modulo 4 to `word_addr[1:0]`. For example, start 10 gives 10, 11, 00, 01.
- R7: With the captured order mode 1 (interleaved), beat k has `word_addr[1:0]` = start XOR k. For example, start 10 gives 10, 11, 00, 01, and start 01 gives 01, 00, 11, 10.
- R8: After the fourth beat, a further advance returns `word_addr[1:0]` to the loaded start value.
- R9: An accepted strobe on the same edge as a low `advance_n` loads the new address and restarts the burst at beat 0.
- R10: After a load, `cpu_started` is 1 if the processor strobe was accepted on that edge (even when the controller strobe was also low), and 0 if only the controller strobe was low.
- R11: `order_il` is captured on the first clock edge after the internal reset releases. Later changes on it do not change the beat order.
- R12: Asserting `rst_n` low at once sets `word_addr` to 0, `selected` to 0 and `cpu_started` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_in | input | ADDR_W | External word address |
| chip_en_n | input | 1 | Active-low chip enable; also gates the processor strobe |
| sel_hi | input | 1 | Active-high chip select |
| sel_lo_n | input | 1 | Active-low chip select |
| strobe_cpu_n | input | 1 | Active-low processor address strobe |
| strobe_ctl_n | input | 1 | Active-low controller address strobe |
| advance_n | input | 1 | Active-low burst advance; high suspends the burst |
| order_il | input | 1 | Beat order pin: 0 linear, 1 interleaved (static) |
| word_addr | output | ADDR_W | Internal word address for the current beat |
| selected | output | 1 | 1 when the last accepted strobe selected the device |
| cpu_started | output | 1 | 1 when the current access was started by the processor strobe |

## Verification
The hardest case to reach is the order pin changing after it has been captured. The only visible effect is a beat sequence that must not change. The bench first resets with the pin high and loads a start value whose linear and interleaved successors differ. It then drops the pin and advances, so a design that follows the live pin shows a wrong low-bit pair. The bench also places the processor strobe with chip enable high on an advancing edge, and a load on an advancing edge, so that both the gating and the priority of a load over an advance show up at the address outputs.

// File: rtl/bas_pkg.sv
package bas_pkg;

  localparam int BAS_BEAT_W = 2;

  typedef enum logic [2:0] {
    CMD_HOLD,
    CMD_STEP,
    CMD_LOAD_CPU,
    CMD_LOAD_CTL,
    CMD_DESEL
  } bas_cmd_e;

endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode
  import bas_pkg::*;
(
  input  logic     chip_en_n,
  input  logic     sel_hi,
  input  logic     sel_lo_n,
  input  logic     strobe_cpu_n,
  input  logic     strobe_ctl_n,
  input  logic     advance_n,
  output bas_cmd_e cmd
);

  logic cpu_act;
  logic ctl_act;
  logic chip_ok;

  assign cpu_act = ~chip_en_n & ~strobe_cpu_n;
  assign ctl_act = ~strobe_ctl_n;
  assign chip_ok = ~chip_en_n & sel_hi & ~sel_lo_n;

  always_comb begin
    if (cpu_act || ctl_act) begin
      if (!chip_ok)     cmd = CMD_DESEL;
      else if (cpu_act) cmd = CMD_LOAD_CPU;
      else              cmd = CMD_LOAD_CTL;
    end else if (!advance_n) begin
      cmd = CMD_STEP;
    end else begin
      cmd = CMD_HOLD;
    end
  end

endmodule

// File: rtl/bas_addr_state.sv
module bas_addr_state
  import bas_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  bas_cmd_e                     cmd,
  input  logic [ADDR_W-1:0]            addr_in,
  output logic [ADDR_W-1:BAS_BEAT_W]   upper_q,
  output logic [BAS_BEAT_W-1:0]        base_q,
  output logic [BAS_BEAT_W-1:0]        beat_q,
  output logic                         sel_q,
  output logic                         cpu_q
);

  logic                        load_en;
  logic                        beat_en;
  logic                        flag_en;
  logic [ADDR_W-1:BAS_BEAT_W]  upper_d;
  logic [BAS_BEAT_W-1:0]       base_d;
  logic [BAS_BEAT_W-1:0]       beat_d;
  logic                        sel_d;
  logic                        cpu_d;

  always_comb begin
    load_en = (cmd == CMD_LOAD_CPU) || (cmd == CMD_LOAD_CTL);
    beat_en = load_en || (cmd == CMD_STEP);
    flag_en = load_en || (cmd == CMD_DESEL);
    upper_d = addr_in[ADDR_W-1:BAS_BEAT_W];
    base_d  = addr_in[BAS_BEAT_W-1:0];
    beat_d  = load_en ? '0 : beat_q + BAS_BEAT_W'(1);
    sel_d   = load_en;
    cpu_d   = (cmd == CMD_LOAD_CPU);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      base_q  <= '0;
      beat_q  <= '0;
      sel_q   <= 1'b0;
      cpu_q   <= 1'b0;
    end else begin
      if (load_en) begin
        upper_q <= upper_d;
        base_q  <= base_d;
      end
      if (beat_en) beat_q <= beat_d;
      if (flag_en) begin
        sel_q <= sel_d;
        cpu_q <= cpu_d;
      end
    end
  end

endmodule

// File: rtl/bas_order_map.sv
module bas_order_map
  import bas_pkg::*;
(
  input  logic [BAS_BEAT_W-1:0] base,
  input  logic [BAS_BEAT_W-1:0] beat,
  input  logic                  interleave,
  output logic [BAS_BEAT_W-1:0] low
);

  logic [BAS_BEAT_W-1:0] low_lin;
  logic [BAS_BEAT_W-1:0] low_xor;

  assign low_lin = base + beat;
  assign low_xor = base ^ beat;
  assign low     = interleave ? low_xor : low_lin;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              chip_en_n,
  input  logic              sel_hi,
  input  logic              sel_lo_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              advance_n,
  input  logic              order_il,
  output logic [ADDR_W-1:0] word_addr,
  output logic              selected,
  output logic              cpu_started
);

  localparam int SYNC_D = 2;

  logic [SYNC_D-1:0]          rst_sync_q;
  logic                       rst_int_n;
  logic                       order_q;
  logic                       order_d;
  logic                       cfg_done_q;
  logic                       cfg_en;
  bas_cmd_e                   cmd;
  logic [ADDR_W-1:BAS_BEAT_W] upper_q;
  logic [BAS_BEAT_W-1:0]      base_q;
  logic [BAS_BEAT_W-1:0]      beat_q;
  logic [BAS_BEAT_W-1:0]      low;

  // reset: asserted at once, released after SYNC_D edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_D-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_D-1];

  // order pin captured once after reset release
  always_comb begin
    cfg_en  = ~cfg_done_q;
    order_d = order_il;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      order_q    <= 1'b0;
      cfg_done_q <= 1'b0;
    end else if (cfg_en) begin
      order_q    <= order_d;
      cfg_done_q <= 1'b1;
    end
  end

  bas_cmd_decode u_dec (
    .chip_en_n    (chip_en_n),
    .sel_hi       (sel_hi),
    .sel_lo_n     (sel_lo_n),
    .strobe_cpu_n (strobe_cpu_n),
    .strobe_ctl_n (strobe_ctl_n),
    .advance_n    (advance_n),
    .cmd          (cmd)
  );

  bas_addr_state #(.ADDR_W(ADDR_W)) u_state (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cmd     (cmd),
    .addr_in (addr_in),
    .upper_q (upper_q),
    .base_q  (base_q),
    .beat_q  (beat_q),
    .sel_q   (selected),
    .cpu_q   (cpu_started)
  );

  bas_order_map u_map (
    .base       (base_q),
    .beat       (beat_q),
    .interleave (order_q),
    .low        (low)
  );

  assign word_addr = {upper_q, low};

endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              chip_en_n,
  input logic              sel_hi,
  input logic              sel_lo_n,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              advance_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] word_addr,
  input logic              selected,
  input logic              cpu_started,
  input logic              order_mode
);

  logic cpu_act;
  logic any_act;
  logic chip_ok;

  assign cpu_act = ~chip_en_n & ~strobe_cpu_n;
  assign any_act = cpu_act | ~strobe_ctl_n;
  assign chip_ok = ~chip_en_n & sel_hi & ~sel_lo_n;

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (chip_ok && any_act) |=> (word_addr == $past(addr_in)) && selected);

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (chip_en_n && !strobe_cpu_n && strobe_ctl_n && advance_n)
      |=> $stable(word_addr) && $stable(selected) && $stable(cpu_started));

  p_desel_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!chip_ok && any_act) |=> !selected && !cpu_started && $stable(word_addr));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (!any_act && advance_n) |=> $stable(word_addr) && $stable(selected));

  p_upper_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (!any_act) |=> $stable(word_addr[ADDR_W-1:2]));

  p_linear_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (!any_act && !advance_n && !order_mode)
      |=> word_addr[1:0] == $past(word_addr[1:0]) + 2'd1);

  p_flag_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (chip_ok && any_act) |=> cpu_started == $past(cpu_act));

endmodule

bind burst_addr_seq bas_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst_ok       (rst_int_n),
  .chip_en_n    (chip_en_n),
  .sel_hi       (sel_hi),
  .sel_lo_n     (sel_lo_n),
  .strobe_cpu_n (strobe_cpu_n),
  .strobe_ctl_n (strobe_ctl_n),
  .advance_n    (advance_n),
  .addr_in      (addr_in),
  .word_addr    (word_addr),
  .selected     (selected),
  .cpu_started  (cpu_started),
  .order_mode   (order_q)
);

// File: tb/burst_addr_seq_tb_top.sv
module burst_addr_seq_tb_top;

  localparam int AW = 8;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          chip_en_n, sel_hi, sel_lo_n;
  logic          strobe_cpu_n, strobe_ctl_n, advance_n, order_il;
  logic [AW-1:0] word_addr;
  logic          selected, cpu_started;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .chip_en_n(chip_en_n), .sel_hi(sel_hi), .sel_lo_n(sel_lo_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .advance_n(advance_n), .order_il(order_il),
    .word_addr(word_addr), .selected(selected), .cpu_started(cpu_started)
  );

  // flags {chip_en_n, sel_hi, sel_lo_n, strobe_cpu_n, strobe_ctl_n, advance_n},
  // addr_in, expected word_addr, expected selected, expected cpu_started, req
  localparam logic [27:0] VEC [0:NV-1] = '{
    {6'b010101, 8'h52, 8'h52, 1'b1, 1'b0, 4'd1},  // R1 controller load
    {6'b010110, 8'h00, 8'h53, 1'b1, 1'b0, 4'd6},  // R6 linear beat 2
    {6'b010110, 8'hFF, 8'h50, 1'b1, 1'b0, 4'd5},  // R5 upper bits kept
    {6'b010110, 8'h00, 8'h51, 1'b1, 1'b0, 4'd6},  // R6 linear beat 4
    {6'b010110, 8'h00, 8'h52, 1'b1, 1'b0, 4'd8},  // R8 wrap to start
    {6'b010111, 8'h00, 8'h52, 1'b1, 1'b0, 4'd4},  // R4 suspend
    {6'b010011, 8'hA5, 8'hA5, 1'b1, 1'b1, 4'd1},  // R1 processor load
    {6'b010110, 8'h00, 8'hA6, 1'b1, 1'b1, 4'd6},  // R6
    {6'b110010, 8'h3C, 8'hA7, 1'b1, 1'b1, 4'd2},  // R2 gated strobe -> advance
    {6'b110101, 8'h3C, 8'hA7, 1'b0, 1'b0, 4'd3},  // R3 chip enable high
    {6'b000101, 8'h66, 8'hA7, 1'b0, 1'b0, 4'd3},  // R3 select low
    {6'b011011, 8'h77, 8'hA7, 1'b0, 1'b0, 4'd3},  // R3 low-true select high
    {6'b010100, 8'h0F, 8'h0F, 1'b1, 1'b0, 4'd9},  // R9 load beats advance
    {6'b010110, 8'h00, 8'h0C, 1'b1, 1'b0, 4'd6},  // R6 11 -> 00
    {6'b010001, 8'hFE, 8'hFE, 1'b1, 1'b1, 4'd10}, // R10 both strobes
    {6'b010110, 8'h00, 8'hFF, 1'b1, 1'b1, 4'd6},  // R6
    {6'b010100, 8'h11, 8'h11, 1'b1, 1'b0, 4'd9},  // R9 restart mid burst
    {6'b010110, 8'h00, 8'h12, 1'b1, 1'b0, 4'd6}   // R6
  };

  task automatic summary_and_end();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 20000", cyc);
      summary_and_end();
    end
  end

  task automatic drive(input logic [5:0] f, input logic [AW-1:0] a);
    {chip_en_n, sel_hi, sel_lo_n, strobe_cpu_n, strobe_ctl_n, advance_n} = f;
    addr_in = a;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [AW-1:0] ea,
                     input logic es, input logic ec);
    n_cmp++;
    if (word_addr !== ea || selected !== es || cpu_started !== ec) begin
      n_bad++;
      $display("FAIL %s: actual addr=%h sel=%b cpu=%b expected addr=%h sel=%b cpu=%b",
               req, word_addr, selected, cpu_started, ea, es, ec);
    end
  endtask

  task automatic do_reset(input logic ord);
    rst_n    = 1'b0;
    order_il = ord;
    {chip_en_n, sel_hi, sel_lo_n, strobe_cpu_n, strobe_ctl_n, advance_n} = 6'b010111;
    addr_in  = '0;
    repeat (3) @(posedge clk);
    #2;
    chk("R12", 8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) drive(6'b010111, 8'h00);
  endtask

  initial begin
    do_reset(1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][27:22], VEC[i][21:14]);
      chk($sformatf("R%0d", VEC[i][3:0]), VEC[i][13:6], VEC[i][5], VEC[i][4]);
    end

    // R12: reset mid burst clears outputs at once
    rst_n = 1'b0;
    #3;
    chk("R12", 8'h00, 1'b0, 1'b0);

    // R7: interleaved order, start 10 then start 01
    do_reset(1'b1);
    drive(6'b010101, 8'h32); chk("R7", 8'h32, 1'b1, 1'b0);
    drive(6'b010110, 8'h00); chk("R7", 8'h33, 1'b1, 1'b0);
    drive(6'b010110, 8'h00); chk("R7", 8'h30, 1'b1, 1'b0);
    drive(6'b010110, 8'h00); chk("R7", 8'h31, 1'b1, 1'b0);
    drive(6'b010110, 8'h00); chk("R8", 8'h32, 1'b1, 1'b0);
    drive(6'b010011, 8'h91); chk("R7", 8'h91, 1'b1, 1'b1);
    drive(6'b010110, 8'h00); chk("R7", 8'h90, 1'b1, 1'b1);
    drive(6'b010110, 8'h00); chk("R7", 8'h93, 1'b1, 1'b1);
    drive(6'b010110, 8'h00); chk("R7", 8'h92, 1'b1, 1'b1);

    // R11: pin dropped after capture, order stays interleaved
    order_il = 1'b0;
    drive(6'b010101, 8'h45); chk("R11", 8'h45, 1'b1, 1'b0);
    drive(6'b010110, 8'h00); chk("R11", 8'h44, 1'b1, 1'b0);
    drive(6'b010110, 8'h00); chk("R11", 8'h47, 1'b1, 1'b0);

    summary_and_end();
  end

endmodule